// File: doc/BRIEF.md
# VSYNC-Clocked Display Identification Byte Streamer

This block sends display identification bytes to a host over a single open-drain data line. No system-clock divider sets the bit rate. Each rising edge of the incoming vertical sync signal moves the line on by one bit. The vertical sync signal arrives from outside, so it is first brought into the system clock domain through a short synchroniser, and only its rising edges are acted on.

Software supplies the bytes one at a time through a write port into a one-byte holding buffer. Each time a packet ends, the shifter takes the byte in the buffer. It sends the eight data bits, most significant bit first, and then one separator bit at the released (high) level, so every packet is nine bits long. When the shifter takes the byte, a buffer-empty flag is set. That flag drives the interrupt output unless the interrupt enable bit is low. The flag clears when software writes the next byte. If no byte arrives in time, the same byte is sent again.

The write port uses a valid/ready handshake, but it never applies back-pressure. `wr_ready` is always high and a write is taken in any cycle that has `wr_valid` high. A second write before the next reload replaces the buffered byte. The data line is driven only while the mode input selects the VSYNC-clocked mode. In any other mode the line stays released and the packet position returns to the separator slot.

Top module: `ddc1_edid_tx`

## Requirements
- R1: After reset, `buf_empty` and `irq` are 0, the line is released (`sda_pull_low` = 0), the packet position is the separator slot, and the buffer holds 8'h00.
- R2: While `ddc1_mode` is 1, each synchronised rising edge of `vsync` moves the line to the next data bit, most significant bit first. `sda_pull_low` is 1 exactly when the current data bit is 0. A rising edge sampled at clock edge k affects the line after clock edge k+2.
- R3: The ninth bit of every packet, which follows data bit 0, is the separator, and the line is released during it.
- R4: The rising edge that ends a separator bit loads the buffered byte into the shifter and sets `buf_empty`.
- R5: `wr_ready` is always 1. A write (`wr_valid` = 1) stores `wr_data` in the buffer, replaces any byte not yet taken, and clears `buf_empty` on the next clock edge.
- R6: `irq` equals `buf_empty` AND `irq_en`.
- R7: If no write takes place between two reloads, the second reload sends the same byte again.
- R8: While `ddc1_mode` is 0, the line is released, `vsync` edges are ignored, and the packet position is held at the separator slot. The first rising edge after the mode returns starts a new packet.
- R9: If a write and a reload fall in the same clock, the shifter takes the old buffered byte, the buffer keeps the new byte, and `buf_empty` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ddc1_mode | input | 1 | 1 selects the VSYNC-clocked streaming mode |
| vsync | input | 1 | Asynchronous vertical sync input, used as the bit clock |
| wr_valid | input | 1 | Write request for the holding buffer |
| wr_ready | output | 1 | Always 1; the buffer accepts a write in every cycle |
| wr_data | input | 8 | Byte to be buffered |
| irq_en | input | 1 | Interrupt enable (mask) for the buffer-empty flag |
| buf_empty | output | 1 | Set when the shifter takes the buffered byte; cleared by a write |
| irq | output | 1 | Buffer-empty interrupt after masking |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low; 0 releases it |

## Verification
Two events can fall in the same clock: a software write and a shifter reload. The first clears the buffer-empty flag and the second sets it. The bench predicts from its model which clock edge will see the reload that ends a separator bit, and it raises `wr_valid` for exactly that cycle. It then checks three things: the old byte appears on the line, the flag stays clear, and the following packet carries the new byte. The bench also runs mode changes in the middle of a packet and several `vsync` periods, including the fastest one the synchroniser can follow.

// File: rtl/ddc1_edid_pkg.sv
package ddc1_edid_pkg;
  localparam int BYTE_BITS = 8;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/vsync_rise_detect.sv
module vsync_rise_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= async_in;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[s] <= 1'b0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

  // R2: a detected edge is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/edid_hold_buf.sv
module edid_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              take,
  input  logic              irq_en,
  output logic [DATA_W-1:0] held_byte,
  output logic              empty_flag,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_byte  <= '0;
      empty_flag <= 1'b0;
    end else begin
      if (wr_fire) held_byte <= wr_byte;
      if (wr_fire)   empty_flag <= 1'b0;
      else if (take) empty_flag <= 1'b1;
    end
  end

  assign irq = empty_flag & irq_en;

  // R5: a write always leaves the flag clear
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !empty_flag);
  // R4: a reload without a write sets the flag
  a_r4_take_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_fire) |=> empty_flag);
  // R9: collision keeps the new byte buffered
  a_r9_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_fire) |=> (held_byte == $past(wr_byte)) && !empty_flag);
  // R7: without a write the buffered byte is unchanged
  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(held_byte));
endmodule

// File: rtl/packet_shifter.sv
module packet_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              step,
  input  logic [DATA_W-1:0] fill_byte,
  output logic              load,
  output logic              line_bit
);
  localparam logic [CNT_W-1:0] SEP_SLOT = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  slot;
  logic [DATA_W-1:0] shreg;

  assign load = active & step & (slot == SEP_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= SEP_SLOT;
      shreg <= '0;
    end else if (!active) begin
      slot <= SEP_SLOT;
    end else if (step) begin
      if (slot == SEP_SLOT) begin
        slot  <= '0;
        shreg <= fill_byte;
      end else begin
        slot  <= CNT_W'(slot + 1'b1);
        shreg <= shreg << 1;
      end
    end
  end

  assign line_bit = (slot == SEP_SLOT) ? 1'b1 : shreg[DATA_W-1];

  // R2: one slot per detected edge
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && slot != SEP_SLOT) |=> slot == CNT_W'($past(slot) + 1'b1));
  // R2: no edge, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step) |=> $stable(slot) && $stable(shreg));
  // R8: leaving the mode parks at the separator slot
  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> slot == SEP_SLOT);
  // R4: a reload copies the buffered byte
  a_r4_reload_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> shreg == $past(fill_byte) && slot == '0);
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx
  import ddc1_edid_pkg::*;
#(
  parameter int DATA_W      = BYTE_BITS,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddc1_mode,
  input  logic              vsync,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  output logic              buf_empty,
  output logic              irq,
  output logic              sda_pull_low
);
  logic              vs_rise;
  logic              reload;
  logic              line_bit;
  logic [DATA_W-1:0] held_byte;
  logic              wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  vsync_rise_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(vsync), .rise(vs_rise)
  );

  edid_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_byte(wr_data),
    .take(reload), .irq_en(irq_en), .held_byte(held_byte),
    .empty_flag(buf_empty), .irq(irq)
  );

  packet_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(ddc1_mode), .step(vs_rise),
    .fill_byte(held_byte), .load(reload), .line_bit(line_bit)
  );

  assign sda_pull_low = ddc1_mode & ~line_bit;

  // R8: line released outside the mode
  a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
    !ddc1_mode |-> !sda_pull_low);
  // R6: interrupt never raised without the flag
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_empty && irq_en);
  // R2: the line changes only after a detected edge or a mode change
  a_r2_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(vs_rise) && $stable(ddc1_mode) && $past(ddc1_mode)) |-> $stable(sda_pull_low));
endmodule

// File: tb/ddc1_edid_tx_test.sv
module ddc1_edid_tx_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ddc1_mode = 1'b0;
  logic vsync = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq_en = 1'b0;
  logic wr_ready, buf_empty, irq, sda_pull_low;

  int checks = 0;
  int fails = 0;
  int half = 3;
  bit vs_run = 1'b0;
  bit done = 1'b0;

  // reference model state
  int cnt = 8;
  int sh = 0;
  int bufv = 0;
  bit flag = 1'b0;
  bit last0 = 0, last1 = 0, last2 = 0;
  bit wrote_since = 1'b0;
  bit resend = 1'b0;
  string evt = "R1";

  always #(CLK_P/2) clk = ~clk;

  ddc1_edid_tx uut (
    .clk(clk), .rst_n(rst_n), .ddc1_mode(ddc1_mode), .vsync(vsync),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .irq_en(irq_en), .buf_empty(buf_empty), .irq(irq),
    .sda_pull_low(sda_pull_low)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // vsync generator
  int vcnt = 0;
  always @(negedge clk) begin
    if (vs_run) begin
      vcnt++;
      if (vcnt >= half) begin
        vcnt = 0;
        vsync <= ~vsync;
      end
    end
  end

  // cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 8; sh = 0; bufv = 0; flag = 0;
      last0 = 0; last1 = 0; last2 = 0;
      wrote_since = 0; resend = 0; evt = "R1";
    end else begin
      bit rise, took;
      rise = last1 && !last2;
      took = 0;
      if (!ddc1_mode) cnt = 8;
      else if (rise) begin
        if (cnt == 8) begin
          sh = bufv; cnt = 0; flag = 1; took = 1;
          resend = !wrote_since; wrote_since = 0;
        end else cnt++;
      end
      if (wr_valid) begin
        bufv = wr_data; flag = 0; wrote_since = 1;
        evt = took ? "R9" : "R5";
      end else if (took) evt = "R4";
      last2 = last1; last1 = last0; last0 = vsync;
    end
  end

  // comparison every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      int exp_low;
      string tag;
      exp_low = (ddc1_mode && cnt < 8 && (((sh >> (7 - cnt)) & 1) == 0)) ? 1 : 0;
      if (!ddc1_mode) tag = "R8";
      else if (cnt == 8) tag = "R3";
      else if (resend) tag = "R7";
      else tag = "R2";
      check(tag, sda_pull_low, exp_low);
      check(evt, buf_empty, flag);
      check("R6", irq, flag & irq_en);
      check("R5", wr_ready, 1);
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_flag();
    while (!flag) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", buf_empty, 0);
    check("R1", irq, 0);
    check("R1", sda_pull_low, 0);
    ddc1_mode = 1'b1;
    irq_en = 1'b1;
    put(8'hA5);
    vs_run = 1'b1;
    wait_flag();
    put(8'h3C);
    repeat (260) @(negedge clk);   // R7: no refill, byte repeats
    irq_en = 1'b0;                 // R6: masked
    wait_flag();
    put(8'h5A);
    repeat (40) @(negedge clk);
    irq_en = 1'b1;
    ddc1_mode = 1'b0;              // R8: mode left mid-packet
    repeat (50) @(negedge clk);
    put(8'hF0);
    ddc1_mode = 1'b1;
    repeat (80) @(negedge clk);
    // R9: write in the exact reload cycle
    while (!(ddc1_mode && cnt == 8 && last1 && !last2)) @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h81;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (200) @(negedge clk);
    half = 1;                      // fastest edge rate
    put(8'h00);
    repeat (60) @(negedge clk);
    put(8'hFF);
    put(8'h6E);                    // R5: overwrite before reload
    repeat (60) @(negedge clk);
    while (!(ddc1_mode && cnt == 8 && last1 && !last2)) @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h17;
    @(negedge clk);
    wr_valid = 1'b0;
    half = 5;
    repeat (300) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule